// File: doc/BRIEF.md
# Segmented Threshold Scheduler with Update Guard

This block steps a comparator threshold through a short schedule while the receive window of an echo pick-off path is open. Software supplies a small table of two to four segments. Each segment has a start offset, a threshold code and a hysteresis code. At each transmit burst the block loads the first segment's codes into an external DAC during blanking. While the window is open it counts cycles. When the count reaches the next segment's start offset, it loads that segment's codes with a one-cycle strobe.

Every load made inside the window is treated as a short blanking event. The block raises an acceptance-inhibit output on the strobe cycle and keeps it high for a programmed number of settle cycles. The downstream gate logic must not accept comparator events while this output is high. The table is checked when each burst starts:
- A malformed table is flagged. The block then holds the first segment for the whole burst.
- A table whose thresholds both rise and fall is reported by a separate warning.

Top module: `sts_sched`

## Requirements
- R1: A cycle with `tx_start` high loads the codes of segment 0. In the next cycle `dac_load` is high for one cycle and `accept_inhibit` is low.
- R2: The start offset of segment i+1 is field i of `seg_start_flat` (bits i*OFS_W and up). It is counted from the cycle in which `win_start` is high. If that offset is B, the codes of segment i+1 appear on `dac_vth`/`dac_vhys` B+2 cycles after the `win_start` cycle. `dac_load` is high for exactly that one cycle.
- R3: For every in-window load, `accept_inhibit` is high on the strobe cycle and on the following `settle_len` cycles, then falls. With `settle_len` = 0 it is high only on the strobe cycle.
- R4: If a load occurs while a guard is still running, the settle count restarts from that load.
- R5: Only segments with index below `seg_count` are used. After the last used segment no further load occurs in that window.
- R6: When `hys_en` is low, every load drives `dac_vhys` to 0. When `hys_en` is high, `dac_vhys` carries the segment's code, taken from field i of `seg_hys_flat`. Field i of `seg_vth_flat` holds the threshold code of segment i.
- R7: A table is invalid in either of these cases:
  - `seg_count` is outside 2..4.
  - A used start offset is not strictly above the previous one, with the first offset required to be at least 1.
  
  The table is judged at `tx_start`. For an invalid table, `table_err` is high from the next cycle until the next `tx_start`. No in-window load or inhibit occurs, and segment 0 codes are held.
- R8: `order_warn` is latched at `tx_start`. It is high when the table is valid and the threshold codes of the used segments include at least one strict rise and at least one strict fall between neighbours.
- R9: A segment boundary that falls in the same cycle as `win_end` is dropped. No load occurs after the window closes.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start | input | 1 | Burst start pulse; loads segment 0 and latches table checks |
| win_start | input | 1 | Valid window opens; offset counter starts |
| win_end | input | 1 | Valid window closes |
| seg_count | input | 3 | Number of used segments (2..4) |
| seg_start_flat | input | 36 | Start offsets of segments 1..3, OFS_W bits each |
| seg_vth_flat | input | 40 | Threshold codes of segments 0..3, TH_W bits each |
| seg_hys_flat | input | 24 | Hysteresis codes of segments 0..3, HY_W bits each |
| hys_en | input | 1 | Enables scheduling of the hysteresis code |
| settle_len | input | 8 | Settle cycles after each in-window load |
| dac_vth | output | 10 | Threshold code to the DAC |
| dac_vhys | output | 6 | Hysteresis code to the DAC |
| dac_load | output | 1 | One-cycle DAC load strobe |
| accept_inhibit | output | 1 | Blocks comparator event acceptance |
| table_err | output | 1 | Latched invalid-table flag |
| order_warn | output | 1 | Latched non-monotonic threshold flag |

## Verification
Two functions can land on the same cycle.

The first is a segment boundary colliding with a guard that is still counting down. This is provoked by placing offsets two cycles apart with a settle time of six. The inhibit must then stay high without a gap until `settle_len` cycles after the later strobe.

The second is a boundary colliding with the window-close pulse. This is provoked by ending the window exactly on the boundary cycle. The bench then expects the codes to stay at the earlier segment and no strobe to appear.

Random tables, offsets, settle times and window lengths mix both collisions with ordinary schedules. Every output is compared every cycle against a timeline computed from the requirements.

// File: rtl/sts_pkg.sv
// Shared constants for the segmented threshold scheduler.
// Assumes: segment counts are small (two up to the top's NSEG_MAX).
package sts_pkg;
    // Smallest number of segments a valid table may use.
    localparam int SEG_MIN = 2;
endpackage

// File: rtl/sts_table_check.sv
// Combinational judgement of a segment table.
// Does: checks the segment count range and the strict rise of the used
//       start offsets, and detects threshold codes that change direction.
// Assumes: the table is stable while it is judged (sampled at tx_start).
module sts_table_check
    import sts_pkg::*;
#(
    parameter int NSEG_MAX = 4,
    parameter int NSC_W    = 3,
    parameter int OFS_W    = 12,
    parameter int TH_W     = 10
) (
    input  logic [NSC_W-1:0]             nseg,
    input  logic [(NSEG_MAX-1)*OFS_W-1:0] bnd_flat,
    input  logic [NSEG_MAX*TH_W-1:0]     vth_flat,
    output logic                         tbl_ok,
    output logic                         order_warn
);

    // Judge count range, offset ordering and threshold direction changes.
    always_comb begin
        logic [OFS_W-1:0] cur;
        logic [OFS_W-1:0] prev;
        logic [TH_W-1:0]  ta;
        logic [TH_W-1:0]  tb;
        logic             rise;
        logic             fall;
        tbl_ok = (int'(nseg) >= SEG_MIN) && (int'(nseg) <= NSEG_MAX);
        prev   = '0;
        for (int i = 0; i < NSEG_MAX - 1; i++) begin
            cur = bnd_flat[i*OFS_W +: OFS_W];
            if (i + 1 < int'(nseg)) begin
                if (cur <= prev) tbl_ok = 1'b0;
            end
            prev = cur;
        end
        rise = 1'b0;
        fall = 1'b0;
        for (int i = 1; i < NSEG_MAX; i++) begin
            ta = vth_flat[(i-1)*TH_W +: TH_W];
            tb = vth_flat[i*TH_W +: TH_W];
            if (i < int'(nseg)) begin
                if (tb > ta) rise = 1'b1;
                if (tb < ta) fall = 1'b1;
            end
        end
        order_warn = tbl_ok && rise && fall;
    end

endmodule

// File: rtl/sts_seg_seq.sv
// Window offset counter and segment sequencer.
// Does: counts cycles from window open, and requests a load when the count
//       meets the start offset of the next used segment.
// Assumes: the table stays stable from tx_start until the window closes.
module sts_seg_seq #(
    parameter int NSEG_MAX = 4,
    parameter int NSC_W    = 3,
    parameter int OFS_W    = 12,
    parameter int SEG_W    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tx_start,
    input  logic                          win_start,
    input  logic                          win_end,
    input  logic                          tbl_ok,
    input  logic [NSC_W-1:0]              nseg,
    input  logic [(NSEG_MAX-1)*OFS_W-1:0] bnd_flat,
    output logic                          upd,
    output logic [SEG_W-1:0]              next_seg
);

    logic             active;
    logic [OFS_W-1:0] cnt;
    logic [SEG_W-1:0] seg;
    logic [OFS_W-1:0] bnd_sel;
    logic             more;

    // Pick the start offset of the segment after the current one.
    always_comb begin
        bnd_sel = '0;
        for (int i = 0; i < NSEG_MAX - 1; i++) begin
            if (int'(seg) == i) bnd_sel = bnd_flat[i*OFS_W +: OFS_W];
        end
    end

    // Decide whether a boundary is met this cycle.
    always_comb begin
        more     = (int'(seg) + 1) < int'(nseg);
        next_seg = seg + SEG_W'(1);
        upd      = active && !win_end && !win_start && !tx_start &&
                   tbl_ok && more && (cnt == bnd_sel);
    end

    // Track window activity, the offset count and the current segment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            seg    <= '0;
        end else if (tx_start) begin
            active <= 1'b0;
            cnt    <= '0;
            seg    <= '0;
        end else begin
            if (upd) seg <= next_seg;
            if (win_start) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (win_end) begin
                active <= 1'b0;
            end else if (active && (cnt != '1)) begin
                cnt <= cnt + OFS_W'(1);
            end
        end
    end

    // R5
    seg_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_ok && active) |-> (int'(seg) < int'(nseg)));

    // R9
    close_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && !win_start) |=> !upd);

endmodule

// File: rtl/sts_guard.sv
// Update guard timer.
// Does: raises the inhibit on the strobe cycle of an in-window load and
//       holds it for settle_len further cycles; a new load restarts it.
// Assumes: settle_len is stable while a guard runs.
module sts_guard #(
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             upd,
    input  logic [SET_W-1:0] settle_len,
    output logic             inhibit
);

    logic             gpulse;
    logic [SET_W-1:0] gcnt;

    // Load, hold and count down the settle timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpulse <= 1'b0;
            gcnt   <= '0;
        end else if (clear) begin
            gpulse <= 1'b0;
            gcnt   <= '0;
        end else begin
            gpulse <= upd;
            if (upd) begin
                gcnt <= settle_len;
            end else if (!gpulse && (gcnt != '0)) begin
                gcnt <= gcnt - SET_W'(1);
            end
        end
    end

    // Inhibit covers the strobe cycle and the remaining settle count.
    always_comb inhibit = gpulse || (gcnt != '0);

    // R3
    guard_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clear) |=> inhibit);

    // R3
    guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !upd && (gcnt > SET_W'(1))) |=> inhibit);

    // R4
    guard_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clear) |=> (gcnt == $past(settle_len)));

endmodule

// File: rtl/sts_sched.sv
// Segmented threshold scheduler, top level.
// Does: loads segment 0 codes at burst start, steps through the used
//       segments during the valid window with a one-cycle DAC strobe, and
//       guards every in-window step with an acceptance inhibit.
// Assumes: one tx_start per burst before win_start; table stable per burst.
module sts_sched #(
    parameter  int NSEG_MAX = 4,
    parameter  int TH_W     = 10,
    parameter  int HY_W     = 6,
    parameter  int OFS_W    = 12,
    parameter  int SET_W    = 8,
    localparam int SEG_W    = $clog2(NSEG_MAX),
    localparam int NSC_W    = $clog2(NSEG_MAX + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tx_start,
    input  logic                          win_start,
    input  logic                          win_end,
    input  logic [NSC_W-1:0]              seg_count,
    input  logic [(NSEG_MAX-1)*OFS_W-1:0] seg_start_flat,
    input  logic [NSEG_MAX*TH_W-1:0]      seg_vth_flat,
    input  logic [NSEG_MAX*HY_W-1:0]      seg_hys_flat,
    input  logic                          hys_en,
    input  logic [SET_W-1:0]              settle_len,
    output logic [TH_W-1:0]               dac_vth,
    output logic [HY_W-1:0]               dac_vhys,
    output logic                          dac_load,
    output logic                          accept_inhibit,
    output logic                          table_err,
    output logic                          order_warn
);

    logic             tbl_ok_c;
    logic             warn_c;
    logic             upd;
    logic [SEG_W-1:0] next_seg;
    logic [TH_W-1:0]  vth_nxt;
    logic [HY_W-1:0]  hys_nxt;

    sts_table_check #(
        .NSEG_MAX(NSEG_MAX), .NSC_W(NSC_W), .OFS_W(OFS_W), .TH_W(TH_W)
    ) chk_i (
        .nseg       (seg_count),
        .bnd_flat   (seg_start_flat),
        .vth_flat   (seg_vth_flat),
        .tbl_ok     (tbl_ok_c),
        .order_warn (warn_c)
    );

    sts_seg_seq #(
        .NSEG_MAX(NSEG_MAX), .NSC_W(NSC_W), .OFS_W(OFS_W), .SEG_W(SEG_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_start  (tx_start),
        .win_start (win_start),
        .win_end   (win_end),
        .tbl_ok    (!table_err),
        .nseg      (seg_count),
        .bnd_flat  (seg_start_flat),
        .upd       (upd),
        .next_seg  (next_seg)
    );

    sts_guard #(
        .SET_W(SET_W)
    ) grd_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (tx_start),
        .upd        (upd),
        .settle_len (settle_len),
        .inhibit    (accept_inhibit)
    );

    // Select the codes of the segment being stepped into.
    always_comb begin
        vth_nxt = '0;
        hys_nxt = '0;
        for (int i = 0; i < NSEG_MAX; i++) begin
            if (int'(next_seg) == i) begin
                vth_nxt = seg_vth_flat[i*TH_W +: TH_W];
                hys_nxt = seg_hys_flat[i*HY_W +: HY_W];
            end
        end
    end

    // Drive the DAC codes and strobe; latch the table flags at burst start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_vth    <= '0;
            dac_vhys   <= '0;
            dac_load   <= 1'b0;
            table_err  <= 1'b0;
            order_warn <= 1'b0;
        end else begin
            dac_load <= 1'b0;
            if (tx_start) begin
                dac_vth    <= seg_vth_flat[TH_W-1:0];
                dac_vhys   <= hys_en ? seg_hys_flat[HY_W-1:0] : '0;
                dac_load   <= 1'b1;
                table_err  <= !tbl_ok_c;
                order_warn <= warn_c;
            end else if (upd) begin
                dac_vth  <= vth_nxt;
                dac_vhys <= hys_en ? hys_nxt : '0;
                dac_load <= 1'b1;
            end
        end
    end

    // R1
    tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> (dac_load && !accept_inhibit));

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (table_err && !tx_start) |=> (!dac_load && !accept_inhibit));

    // R9
    close_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && !tx_start) |=> !dac_load);

    // R6
    hys_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hys_en && (tx_start || upd)) |=> (dac_vhys == '0));

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_load && !tx_start && !upd) |=> !dac_load);

endmodule

// File: tb/sts_sched_tb.sv
// Bench for the segmented threshold scheduler: directed corner bursts plus
// seeded random tables, each cycle compared with a computed timeline.
module sts_sched_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSEG_MAX   = 4;
    localparam int TH_W       = 10;
    localparam int HY_W       = 6;
    localparam int OFS_W      = 12;
    localparam int SET_W      = 8;

    logic                          clk = 1'b0;
    logic                          rst_n;
    logic                          tx_start;
    logic                          win_start;
    logic                          win_end;
    logic [2:0]                    seg_count;
    logic [(NSEG_MAX-1)*OFS_W-1:0] seg_start_flat;
    logic [NSEG_MAX*TH_W-1:0]      seg_vth_flat;
    logic [NSEG_MAX*HY_W-1:0]      seg_hys_flat;
    logic                          hys_en;
    logic [SET_W-1:0]              settle_len;
    logic [TH_W-1:0]               dac_vth;
    logic [HY_W-1:0]               dac_vhys;
    logic                          dac_load;
    logic                          accept_inhibit;
    logic                          table_err;
    logic                          order_warn;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int tb_n;
    int tb_b[3];
    int tb_v[4];
    int tb_h[4];
    int tb_hen;
    int tb_settle;

    always #(CLK_PERIOD/2) clk = ~clk;

    sts_sched #(
        .NSEG_MAX(NSEG_MAX), .TH_W(TH_W), .HY_W(HY_W),
        .OFS_W(OFS_W), .SET_W(SET_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start),
        .win_start(win_start), .win_end(win_end), .seg_count(seg_count),
        .seg_start_flat(seg_start_flat), .seg_vth_flat(seg_vth_flat),
        .seg_hys_flat(seg_hys_flat), .hys_en(hys_en),
        .settle_len(settle_len), .dac_vth(dac_vth), .dac_vhys(dac_vhys),
        .dac_load(dac_load), .accept_inhibit(accept_inhibit),
        .table_err(table_err), .order_warn(order_warn)
    );

    task automatic chk(input bit ok, input string tag, input string req,
                       input string fld, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL [%s] %s %s: actual %0d expected %0d",
                     tag, req, fld, act, exp);
        end
    endtask

    // R7: table validity from the requirement.
    function automatic bit tbl_valid();
        int prev = 0;
        if (tb_n < 2 || tb_n > 4) return 1'b0;
        for (int i = 0; i < tb_n - 1; i++) begin
            if (tb_b[i] <= prev) return 1'b0;
            prev = tb_b[i];
        end
        return 1'b1;
    endfunction

    // R8: direction change among the used thresholds.
    function automatic bit tbl_nonmono();
        bit up = 1'b0;
        bit dn = 1'b0;
        if (!tbl_valid()) return 1'b0;
        for (int i = 1; i < tb_n; i++) begin
            if (tb_v[i] > tb_v[i-1]) up = 1'b1;
            if (tb_v[i] < tb_v[i-1]) dn = 1'b1;
        end
        return up && dn;
    endfunction

    task automatic apply_table();
        seg_count = 3'(tb_n);
        for (int i = 0; i < 3; i++) seg_start_flat[i*OFS_W +: OFS_W] = OFS_W'(tb_b[i]);
        for (int i = 0; i < 4; i++) begin
            seg_vth_flat[i*TH_W +: TH_W] = TH_W'(tb_v[i]);
            seg_hys_flat[i*HY_W +: HY_W] = HY_W'(tb_h[i]);
        end
        hys_en     = tb_hen[0];
        settle_len = SET_W'(tb_settle);
    endtask

    // One burst: tx_start at cycle 0, window opens at blank+1, lasts wlen.
    task automatic run_burst(input string tag, input int blank, input int wlen);
        int ws    = blank + 1;
        int we    = ws + wlen;
        int total = we + tb_settle + 5;
        int upt[3];
        int nup   = 0;
        bit valid = tbl_valid();
        bit warn  = tbl_nonmono();
        apply_table();
        if (valid) begin
            for (int i = 0; i < tb_n - 1; i++) begin
                if (tb_b[i] + 1 < wlen) begin
                    upt[nup] = ws + tb_b[i] + 2;
                    nup++;
                end
            end
        end
        for (int k = 0; k <= total; k++) begin
            @(negedge clk);
            if (k > 0) begin
                int seg = 0;
                bit ld  = (k == 1);
                bit inh = 1'b0;
                int ev;
                int eh;
                for (int j = 0; j < nup; j++) begin
                    if (upt[j] <= k) seg = j + 1;
                    if (upt[j] == k) ld = 1'b1;
                    if (upt[j] <= k && k <= upt[j] + tb_settle) inh = 1'b1;
                end
                ev = tb_v[seg];
                eh = tb_hen != 0 ? tb_h[seg] : 0;
                chk(int'(dac_load) == int'(ld), tag, (k == 1) ? "R1" : "R2",
                    "dac_load", int'(dac_load), int'(ld));
                chk(int'(accept_inhibit) == int'(inh), tag, "R3",
                    "accept_inhibit", int'(accept_inhibit), int'(inh));
                chk(int'(dac_vth) == ev, tag, "R2", "dac_vth", int'(dac_vth), ev);
                chk(int'(dac_vhys) == eh, tag, (tb_hen != 0) ? "R2" : "R6",
                    "dac_vhys", int'(dac_vhys), eh);
                chk(int'(table_err) == int'(!valid), tag, "R7",
                    "table_err", int'(table_err), int'(!valid));
                chk(int'(order_warn) == int'(warn), tag, "R8",
                    "order_warn", int'(order_warn), int'(warn));
            end
            tx_start  = (k == 0);
            win_start = (k == ws);
            win_end   = (k == we);
        end
    endtask

    task automatic rand_table();
        int r = int'($urandom % 100);
        if (r < 85) tb_n = 2 + int'($urandom % 3);
        else        tb_n = (r % 2 == 0) ? int'($urandom % 2) : 5 + int'($urandom % 3);
        tb_b[0] = 1 + int'($urandom % 20);
        tb_b[1] = tb_b[0] + 1 + int'($urandom % 20);
        tb_b[2] = tb_b[1] + 1 + int'($urandom % 20);
        if ($urandom % 10 == 0) tb_b[1] = tb_b[0];
        if ($urandom % 12 == 0) tb_b[0] = 0;
        for (int i = 0; i < 4; i++) begin
            tb_v[i] = int'($urandom % 1024);
            tb_h[i] = int'($urandom % 64);
        end
        if ($urandom % 3 == 0) begin
            for (int i = 1; i < 4; i++) if (tb_v[i] < tb_v[i-1]) tb_v[i] = tb_v[i-1];
        end
        tb_hen    = int'($urandom % 2);
        tb_settle = int'($urandom % 8);
    endtask

    task automatic set_table(input int n, input int b0, input int b1, input int b2,
                             input int settle, input int hen);
        tb_n = n; tb_b[0] = b0; tb_b[1] = b1; tb_b[2] = b2;
        tb_settle = settle; tb_hen = hen;
        for (int i = 0; i < 4; i++) begin
            tb_v[i] = 100 + 50 * i;
            tb_h[i] = 3 + 7 * i;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL [watchdog] R10 run_complete: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7351));
        rst_n = 1'b0; tx_start = 1'b0; win_start = 1'b0; win_end = 1'b0;
        set_table(2, 5, 10, 15, 0, 1);
        apply_table();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(dac_vth == '0 && dac_vhys == '0, "reset", "R10", "codes",
            int'(dac_vth) + int'(dac_vhys), 0);
        chk(!dac_load && !accept_inhibit, "reset", "R10", "strobe_inhibit",
            int'(dac_load) + int'(accept_inhibit), 0);
        chk(!table_err && !order_warn, "reset", "R10", "flags",
            int'(table_err) + int'(order_warn), 0);

        // R4: boundaries closer than the settle time
        set_table(4, 3, 5, 7, 6, 1);
        run_burst("R4", 2, 20);
        // R9: second boundary lands on the window-close cycle
        set_table(3, 4, 10, 12, 2, 1);
        run_burst("R9", 3, 11);
        // R5: two segments only, later offsets ignored
        set_table(2, 5, 6, 7, 1, 1);
        run_burst("R5", 1, 30);
        // R6: hysteresis scheduling disabled
        set_table(3, 2, 8, 9, 3, 0);
        run_burst("R6", 2, 15);
        // R3: zero settle time
        set_table(4, 2, 4, 6, 0, 1);
        run_burst("R3", 1, 12);
        // R7: repeated offset, zero first offset, count out of range
        set_table(3, 4, 4, 9, 2, 1);
        run_burst("R7", 2, 20);
        set_table(2, 0, 5, 9, 2, 1);
        run_burst("R7", 2, 20);
        set_table(5, 2, 4, 6, 2, 1);
        run_burst("R7", 2, 20);
        // R8: thresholds rise then fall
        set_table(3, 3, 7, 11, 1, 1);
        tb_v[1] = 900; tb_v[2] = 20;
        run_burst("R8", 2, 20);
        // R1: back-to-back bursts with a short blanking gap
        set_table(2, 1, 9, 9, 4, 1);
        run_burst("R1", 1, 6);

        for (int it = 0; it < 60; it++) begin
            int wl;
            rand_table();
            wl = tb_b[2] + 3 + int'($urandom % 10);
            if ($urandom % 8 == 0) wl = 1 + int'($urandom % (tb_b[1] + 2));
            run_burst("random", 1 + int'($urandom % 4), wl);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule